// File: doc/BRIEF.md
# Packet Page Allocator with Transmit, Completion and Receive Queues

This block manages the packet-buffer pages of a small Ethernet controller. It keeps one bit per page to mark pages in use, and three short queues of page numbers. One queue holds pages waiting to transmit. One holds pages whose transmission has finished. One holds pages that hold received frames. The host drives it with 3-bit memory-manager commands and with separate writes to the packet-number, interrupt-acknowledge and interrupt-mask registers. It reads back the allocation result, both queue heads, the count of pages in use, the interrupt status and the mask.

The network side is reduced to a one-cycle `rx_arrive` strobe, which claims a page for a newly received frame. Transmission is modelled as finishing as soon as it is issued. The frame data path lies outside this block. All effects of one cycle are applied in a fixed order: the host command, then the retry of a pending allocation, then the acknowledge, mask and packet-number writes, then the receive arrival, and last the forced status bits. The result is registered on the next clock edge.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset, `alloc_res` is 0x00, `done_head` and `rx_head` are 0x80, `used_cnt` is 0, `int_stat` is 0x04, `int_mask` is 0, `pnum_q` is 0 and `irq` is low.
- R2: Command code 1 on `cmd_op` (allocate) first sets the result to 0x80 and clears ALLOC (status bit 3). It then claims the lowest-numbered free page. On success `alloc_res` holds that page number and ALLOC is set. With no page free, the result stays 0x80 and ALLOC stays clear.
- R3: A failed allocation stays pending while `alloc_res` reads 0x80. At the end of any command cycle that released a page (codes 4 and 5, or auto-release during a flush), the pending request claims the lowest free page and sets ALLOC.
- R4: `used_cnt` equals the number of pages in use. Code 5 frees the page named by `pnum_q`. Code 2 frees every page, empties all three queues and sets `alloc_res` to 0x00.
- R5: A pulse on `rx_arrive` claims the lowest free page, appends it to the receive queue and sets RCV (status bit 0). It is dropped when no page is free. It is applied after the host command of the same cycle.
- R6: `rx_head` shows the oldest receive entry, or 0x80 when the queue is empty. Code 3 removes the oldest entry and moves the rest forward. Code 4 does the same and also frees that entry's page. RCV is cleared when a removal leaves the queue empty and stays set otherwise.
- R7: Code 6 appends `pnum_q` to the transmit queue. If `tx_en` is high, every queued page is then sent in order. With `auto_rel` high each sent page is freed; otherwise it is appended to the completion queue. The transmit queue is then emptied. `done_head` shows the oldest completion entry, or 0x80 when that queue is empty. Code 7 empties the transmit and completion queues. Code 0 does nothing.
- R8: At the end of every cycle, TX_EMPTY (status bit 2) is set if the transmit queue is empty, and TX (status bit 1) is set if the completion queue is non-empty.
- R9: An acknowledge write clears the status bits selected by `ack_byte & 0xD6`. If `ack_byte` bit 1 is set, it also removes one completion entry.
- R10: `int_mask` takes the value of each mask write. `irq` is high exactly when `int_stat & int_mask` is non-zero.
- R11: Appending to a full queue (transmit, completion or receive) has no effect on that queue.
- R12: A packet-number write stores `pnum_in`, and `pnum_q` reads it back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host command strobe |
| cmd_op | input | 3 | Command code (top three bits of the command byte) |
| pnum_wr | input | 1 | Packet-number register write strobe |
| pnum_in | input | PW | Packet number to store |
| ack_wr | input | 1 | Interrupt acknowledge write strobe |
| ack_byte | input | 8 | Acknowledge value |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_byte | input | 8 | New interrupt mask |
| tx_en | input | 1 | Transmit enable |
| auto_rel | input | 1 | Free pages right after sending |
| rx_arrive | input | 1 | A received frame requests a page |
| alloc_res | output | 8 | Allocation result, 0x80 on failure or pending |
| pnum_q | output | 8 | Packet-number register |
| done_head | output | 8 | Oldest completion entry or 0x80 |
| rx_head | output | 8 | Oldest receive entry or 0x80 |
| used_cnt | output | 8 | Number of pages in use |
| int_stat | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The host command and a receive arrival can both claim a page in the same cycle. Because the command is applied first, its allocation, or the retry of a pending allocation, takes the page, and the arrival sees what is left. A directed cycle provokes this: all pages are in use and an allocation is pending when the host releases one page together with an `rx_arrive` pulse. The bench judges the outcome by whether `alloc_res` names the released page while `rx_head` stays 0x80. Random traffic then mixes commands, acknowledges and arrivals in the same cycles and compares every output against the bench's model.

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr #(
  parameter int NPAGES = 4,
  parameter int PW = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [2:0]    cmd_op,
  input  logic          pnum_wr,
  input  logic [PW-1:0] pnum_in,
  input  logic          ack_wr,
  input  logic [7:0]    ack_byte,
  input  logic          mask_wr,
  input  logic [7:0]    mask_byte,
  input  logic          tx_en,
  input  logic          auto_rel,
  input  logic          rx_arrive,
  output logic [7:0]    alloc_res,
  output logic [7:0]    pnum_q,
  output logic [7:0]    done_head,
  output logic [7:0]    rx_head,
  output logic [7:0]    used_cnt,
  output logic [7:0]    int_stat,
  output logic [7:0]    int_mask,
  output logic          irq
);
  localparam int CW = $clog2(NPAGES + 1);
  localparam logic [CW-1:0] FULL = CW'(NPAGES);
  localparam logic [7:0] FAIL = 8'h80;
  localparam logic [7:0] ACKABLE = 8'hD6;
  localparam int B_ALLOC = 3;
  localparam int B_TXE = 2;
  localparam int B_TX = 1;
  localparam int B_RCV = 0;

  logic [NPAGES-1:0] used_q, n_used;
  logic [PW-1:0] txq [NPAGES];
  logic [PW-1:0] dnq [NPAGES];
  logic [PW-1:0] rxq [NPAGES];
  logic [PW-1:0] n_txq [NPAGES];
  logic [PW-1:0] n_dnq [NPAGES];
  logic [PW-1:0] n_rxq [NPAGES];
  logic [CW-1:0] txl, dnl, rxl, n_txl, n_dnl, n_rxl;
  logic [7:0] res_q, n_res, stat_q, n_stat, mask_q, n_mask;
  logic [PW-1:0] pn_q, n_pn;
  logic rel;
  logic [PW:0] pk;

  function automatic logic [PW:0] pick_free(input logic [NPAGES-1:0] m);
    logic [PW:0] r;
    r = '0;
    for (int i = NPAGES - 1; i >= 0; i--)
      if (!m[i]) r = {1'b1, PW'(i)};
    return r;
  endfunction

  always_comb begin
    n_used = used_q;
    n_txq = txq;
    n_dnq = dnq;
    n_rxq = rxq;
    n_txl = txl;
    n_dnl = dnl;
    n_rxl = rxl;
    n_res = res_q;
    n_stat = stat_q;
    n_mask = mask_q;
    n_pn = pn_q;
    rel = 1'b0;
    pk = '0;

    if (cmd_wr) begin
      case (cmd_op)
        3'd1: begin
          n_res = FAIL;
          n_stat[B_ALLOC] = 1'b0;
          pk = pick_free(n_used);
          if (pk[PW]) begin
            n_used[pk[PW-1:0]] = 1'b1;
            n_res = 8'(pk[PW-1:0]);
            n_stat[B_ALLOC] = 1'b1;
          end
        end
        3'd2: begin
          n_used = '0;
          n_txl = '0;
          n_dnl = '0;
          n_rxl = '0;
          n_res = '0;
        end
        3'd3, 3'd4: begin
          if (n_rxl != '0) begin
            if (cmd_op == 3'd4) begin
              n_used[n_rxq[0]] = 1'b0;
              rel = 1'b1;
            end
            for (int i = 0; i < NPAGES - 1; i++) n_rxq[i] = n_rxq[i+1];
            n_rxl = n_rxl - CW'(1);
          end
          n_stat[B_RCV] = (n_rxl != '0);
        end
        3'd5: begin
          n_used[pn_q] = 1'b0;
          rel = 1'b1;
        end
        3'd6: begin
          if (n_txl != FULL) begin
            for (int i = 0; i < NPAGES; i++)
              if (CW'(i) == n_txl) n_txq[i] = pn_q;
            n_txl = n_txl + CW'(1);
          end
          if (tx_en) begin
            for (int i = 0; i < NPAGES; i++) begin
              if (CW'(i) < n_txl) begin
                if (auto_rel) begin
                  n_used[n_txq[i]] = 1'b0;
                  rel = 1'b1;
                end else if (n_dnl != FULL) begin
                  for (int j = 0; j < NPAGES; j++)
                    if (CW'(j) == n_dnl) n_dnq[j] = n_txq[i];
                  n_dnl = n_dnl + CW'(1);
                end
              end
            end
            n_txl = '0;
          end
        end
        3'd7: begin
          n_txl = '0;
          n_dnl = '0;
        end
        default: ;
      endcase
    end

    if (rel && n_res == FAIL) begin
      pk = pick_free(n_used);
      if (pk[PW]) begin
        n_used[pk[PW-1:0]] = 1'b1;
        n_res = 8'(pk[PW-1:0]);
        n_stat[B_ALLOC] = 1'b1;
      end
    end

    if (ack_wr) begin
      n_stat = n_stat & ~(ack_byte & ACKABLE);
      if (ack_byte[B_TX] && n_dnl != '0) begin
        for (int i = 0; i < NPAGES - 1; i++) n_dnq[i] = n_dnq[i+1];
        n_dnl = n_dnl - CW'(1);
      end
    end
    if (mask_wr) n_mask = mask_byte;
    if (pnum_wr) n_pn = pnum_in;

    if (rx_arrive && n_rxl != FULL) begin
      pk = pick_free(n_used);
      if (pk[PW]) begin
        n_used[pk[PW-1:0]] = 1'b1;
        for (int i = 0; i < NPAGES; i++)
          if (CW'(i) == n_rxl) n_rxq[i] = pk[PW-1:0];
        n_rxl = n_rxl + CW'(1);
        n_stat[B_RCV] = 1'b1;
      end
    end

    if (n_txl == '0) n_stat[B_TXE] = 1'b1;
    if (n_dnl != '0) n_stat[B_TX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      txl <= '0;
      dnl <= '0;
      rxl <= '0;
      res_q <= '0;
      stat_q <= 8'h04;
      mask_q <= '0;
      pn_q <= '0;
      for (int i = 0; i < NPAGES; i++) begin
        txq[i] <= '0;
        dnq[i] <= '0;
        rxq[i] <= '0;
      end
    end else begin
      used_q <= n_used;
      txq <= n_txq;
      dnq <= n_dnq;
      rxq <= n_rxq;
      txl <= n_txl;
      dnl <= n_dnl;
      rxl <= n_rxl;
      res_q <= n_res;
      stat_q <= n_stat;
      mask_q <= n_mask;
      pn_q <= n_pn;
    end
  end

  assign alloc_res = res_q;
  assign pnum_q = 8'(pn_q);
  assign done_head = (dnl == '0) ? FAIL : 8'(dnq[0]);
  assign rx_head = (rxl == '0) ? FAIL : 8'(rxq[0]);
  assign used_cnt = 8'($countones(used_q));
  assign int_stat = stat_q;
  assign int_mask = mask_q;
  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/pkt_page_mgr_chk.sv
module pkt_page_mgr_chk #(
  parameter int NPAGES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [2:0] cmd_op,
  input logic       rx_arrive,
  input logic [7:0] alloc_res,
  input logic [7:0] done_head,
  input logic [7:0] rx_head,
  input logic [7:0] used_cnt,
  input logic [7:0] int_stat
);
  assert_alloc_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_op == 3'd1 && used_cnt == 8'(NPAGES)) |=> (alloc_res == 8'h80 && !int_stat[3]));

  assert_alloc_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_op == 3'd1 && used_cnt < 8'(NPAGES) && !rx_arrive)
      |=> (!alloc_res[7] && int_stat[3] && used_cnt == $past(used_cnt) + 8'd1));

  assert_mmu_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_op == 3'd2 && !rx_arrive)
      |=> (used_cnt == 8'd0 && rx_head == 8'h80 && done_head == 8'h80 && alloc_res == 8'h00));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    used_cnt <= 8'(NPAGES));

  assert_rcv_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_head != 8'h80) |-> int_stat[0]);

  assert_tx_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_head != 8'h80) |-> int_stat[1]);
endmodule

bind pkt_page_mgr pkt_page_mgr_chk #(.NPAGES(NPAGES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .rx_arrive(rx_arrive),
  .alloc_res(alloc_res), .done_head(done_head), .rx_head(rx_head),
  .used_cnt(used_cnt), .int_stat(int_stat)
);

// File: tb/pkt_page_mgr_tb.sv
`timescale 1ns/1ps
module pkt_page_mgr_tb_top;
  localparam int NP = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cmd_wr = 0, pnum_wr = 0, ack_wr = 0, mask_wr = 0, tx_en = 0, auto_rel = 0, rx_arrive = 0;
  logic [2:0] cmd_op = 0;
  logic [PW-1:0] pnum_in = 0;
  logic [7:0] ack_byte = 0, mask_byte = 0;
  logic [7:0] alloc_res, pnum_q, done_head, rx_head, used_cnt, int_stat, int_mask;
  logic irq;

  pkt_page_mgr #(.NPAGES(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .pnum_wr(pnum_wr), .pnum_in(pnum_in), .ack_wr(ack_wr), .ack_byte(ack_byte),
    .mask_wr(mask_wr), .mask_byte(mask_byte), .tx_en(tx_en), .auto_rel(auto_rel),
    .rx_arrive(rx_arrive), .alloc_res(alloc_res), .pnum_q(pnum_q),
    .done_head(done_head), .rx_head(rx_head), .used_cnt(used_cnt),
    .int_stat(int_stat), .int_mask(int_mask), .irq(irq)
  );

  int checks = 0, fails = 0;
  string phase = "R1";
  bit te_s = 0, ar_s = 0;

  logic [NP-1:0] mu;
  int mtx[NP], mdn[NP], mrx[NP];
  int mtxl, mdnl, mrxl, mpn;
  logic [7:0] mres, mstat, mmask;

  function automatic int lowest();
    for (int i = 0; i < NP; i++) if (!mu[i]) return i;
    return -1;
  endfunction

  function automatic int popcnt();
    int c = 0;
    for (int i = 0; i < NP; i++) if (mu[i]) c++;
    return c;
  endfunction

  task automatic m_reset();
    mu = '0; mtxl = 0; mdnl = 0; mrxl = 0; mpn = 0;
    mres = 8'h00; mstat = 8'h04; mmask = 8'h00;
  endtask

  task automatic m_step(bit cw, int op, bit pw, int pv, bit aw, int av, bit kw, int kv,
                        bit te, bit ar, bit rx);
    bit rel = 0;
    int t;
    if (cw) begin
      case (op)
        1: begin
          mres = 8'h80; mstat[3] = 0;
          t = lowest();
          if (t >= 0) begin mu[t] = 1; mres = 8'(t); mstat[3] = 1; end
        end
        2: begin mu = '0; mtxl = 0; mdnl = 0; mrxl = 0; mres = 8'h00; end
        3, 4: begin
          if (mrxl > 0) begin
            if (op == 4) begin mu[mrx[0]] = 0; rel = 1; end
            for (int i = 0; i < NP - 1; i++) mrx[i] = mrx[i+1];
            mrxl--;
          end
          mstat[0] = (mrxl != 0);
        end
        5: begin mu[mpn] = 0; rel = 1; end
        6: begin
          if (mtxl < NP) begin mtx[mtxl] = mpn; mtxl++; end
          if (te) begin
            for (int i = 0; i < mtxl; i++) begin
              if (ar) begin mu[mtx[i]] = 0; rel = 1; end
              else if (mdnl < NP) begin mdn[mdnl] = mtx[i]; mdnl++; end
            end
            mtxl = 0;
          end
        end
        7: begin mtxl = 0; mdnl = 0; end
        default: ;
      endcase
    end
    if (rel && mres == 8'h80) begin
      t = lowest();
      if (t >= 0) begin mu[t] = 1; mres = 8'(t); mstat[3] = 1; end
    end
    if (aw) begin
      mstat = mstat & ~(8'(av) & 8'hD6);
      if (av[1] && mdnl > 0) begin
        for (int i = 0; i < NP - 1; i++) mdn[i] = mdn[i+1];
        mdnl--;
      end
    end
    if (kw) mmask = 8'(kv);
    if (pw) mpn = pv;
    if (rx && mrxl < NP) begin
      t = lowest();
      if (t >= 0) begin mu[t] = 1; mrx[mrxl] = t; mrxl++; mstat[0] = 1; end
    end
    if (mtxl == 0) mstat[2] = 1;
    if (mdnl != 0) mstat[1] = 1;
  endtask

  task automatic chk(string req, string nm, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s (step %s) actual=%02h expected=%02h", req, nm, phase, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2", "alloc_res", alloc_res, mres);
    chk("R4", "used_cnt", used_cnt, 8'(popcnt()));
    chk("R6", "rx_head", rx_head, (mrxl == 0) ? 8'h80 : 8'(mrx[0]));
    chk("R7", "done_head", done_head, (mdnl == 0) ? 8'h80 : 8'(mdn[0]));
    chk("R8", "int_stat", int_stat, mstat);
    chk("R10", "int_mask", int_mask, mmask);
    chk("R10", "irq", {7'd0, irq}, {7'd0, |(mstat & mmask)});
    chk("R12", "pnum_q", pnum_q, 8'(mpn));
  endtask

  task automatic drive(string ph, bit cw, int op, bit pw, int pv, bit aw, int av,
                       bit kw, int kv, bit rx);
    @(negedge clk);
    check_all();
    phase = ph;
    cmd_wr = cw; cmd_op = 3'(op); pnum_wr = pw; pnum_in = PW'(pv);
    ack_wr = aw; ack_byte = 8'(av); mask_wr = kw; mask_byte = 8'(kv);
    tx_en = te_s; auto_rel = ar_s; rx_arrive = rx;
    m_step(cw, op, pw, pv, aw, av, kw, kv, te_s, ar_s, rx);
  endtask

  task automatic cmd(string ph, int op);  drive(ph, 1, op, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic setpn(string ph, int v); drive(ph, 0, 0, 1, v, 0, 0, 0, 0, 0); endtask
  task automatic ack(string ph, int v);   drive(ph, 0, 0, 0, 0, 1, v, 0, 0, 0); endtask
  task automatic msk(string ph, int v);   drive(ph, 0, 0, 0, 0, 0, 0, 1, v, 0); endtask
  task automatic rxin(string ph);         drive(ph, 0, 0, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: lowest-first allocation, then failure
    for (int i = 0; i < NP; i++) cmd("R2", 1);
    cmd("R2", 1);
    // R3: release clears the pending allocation
    setpn("R3", 2);
    cmd("R3", 5);
    // R5: command before arrival in the same cycle
    cmd("R5", 1);
    setpn("R5", 1);
    drive("R5", 1, 5, 0, 0, 0, 0, 0, 0, 1);
    // R5 / R6 / R11: receive path
    cmd("R11", 2);
    for (int i = 0; i < NP; i++) rxin("R5");
    rxin("R11");
    cmd("R6", 3);
    cmd("R6", 4);
    cmd("R6", 4);
    cmd("R6", 4);
    cmd("R6", 3);
    // R7 / R11 / R9: transmit queue and completions
    cmd("R11", 2);
    for (int i = 0; i < NP; i++) cmd("R7", 1);
    te_s = 0; ar_s = 0;
    for (int i = 0; i < NP; i++) begin setpn("R7", i); cmd("R7", 6); end
    cmd("R11", 6);
    te_s = 1;
    cmd("R11", 6);
    ack("R9", 8'h02);
    ack("R9", 8'hFF);
    msk("R10", 8'h0F);
    msk("R10", 8'h00);
    // R3: auto-release during flush serves the pending request
    cmd("R3", 2);
    for (int i = 0; i < NP; i++) cmd("R3", 1);
    cmd("R3", 1);
    ar_s = 1;
    setpn("R3", 3);
    cmd("R3", 6);
    cmd("R7", 7);
    cmd("R7", 0);

    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 7);
      if (op == 2 && $urandom_range(0, 3) != 0) op = 1;
      if ($urandom_range(0, 15) == 0) te_s = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) ar_s = $urandom_range(0, 1);
      drive("RND", $urandom_range(0, 1), op, $urandom_range(0, 3) == 0, $urandom_range(0, NP - 1),
            $urandom_range(0, 3) == 0, $urandom_range(0, 255),
            $urandom_range(0, 7) == 0, $urandom_range(0, 255), $urandom_range(0, 2) == 0);
    end
    drive("END", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule